// File: doc/BRIEF.md
# Packed Saturating Lane Arithmetic Unit

This unit treats each of two 64-bit source words as a row of equal-width lanes of 8, 16, 32 or 64 bits. It applies one operation to every lane pair in parallel: add, subtract, minimum or maximum. An 8-bit control word sets how each lane behaves. With the saturate bit clear, add and subtract wrap. With the saturate bit set, they clamp to the lane's range. The signed bit picks whether that range is signed or unsigned, and it also picks signed or unsigned comparison for minimum and maximum.

A scalar bit limits the work to the lowest lane. The upper lanes are then copied from the first source. The result is registered and appears one clock after an input valid pulse, together with a one-cycle valid strobe. Carries and borrows never cross from one lane into the next.

Top module: `packed_lane_alu`

## Requirements
- R1: `lane_sz` sets the lane width: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 = 64 bits. Every lane is computed independently, and no carry or borrow passes into a neighbouring lane.
- R2: `op` selects the operation: 0 = add, 1 = subtract (src_a minus src_b), 2 = minimum, 3 = maximum. With `ctrl[1]` (saturate) clear, add and subtract wrap modulo 2^width, whatever the value of `ctrl[6]`.
- R3: Unsigned saturating add (`ctrl[1]`=1, `ctrl[6]`=0): if the lane sum carries out of the lane, the lane result is all ones.
- R4: Unsigned saturating subtract: if the src_b lane is larger than the src_a lane, the lane result is zero.
- R5: Signed saturating add (`ctrl[1]`=1, `ctrl[6]`=1): overflow occurs when both operand signs agree and the wrapped sign differs. The lane then clamps to the most negative value if the wrapped sign is 0, and to the most positive value otherwise.
- R6: Signed saturating subtract uses the rule of R5, with the sign of src_b inverted when testing for overflow.
- R7: Minimum and maximum compare two's-complement values when `ctrl[6]`=1 and raw unsigned bits when it is 0. The winning operand's lane bits are written unchanged. On a tie, src_b's lane is written.
- R8: With `ctrl[7]` (scalar) set, only the lowest lane is computed. All bits above it are copied from src_a.
- R9: `res` and `out_valid` update on the clock edge after a cycle with `in_valid` high. `out_valid` is high for exactly one cycle per accepted input. `res` holds its value while no input is accepted.
- R10: A synchronous reset (`rst` high at a clock edge) clears `res` to zero and `out_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept the operands this cycle |
| src_a | input | 64 | First packed operand |
| src_b | input | 64 | Second packed operand |
| lane_sz | input | 2 | Lane width code |
| op | input | 2 | Operation code |
| ctrl | input | 8 | Control flags: bit 1 saturate, bit 6 signed, bit 7 scalar |
| res | output | 64 | Registered packed result |
| out_valid | output | 1 | One-cycle strobe marking a new result |

## Verification
Every lane width, operation and flag combination is driven with lane values replicated across the word: zero, all ones, the most negative value, the most positive value and one. These values sit exactly on the carry, borrow and sign-overflow edges, so they separate a wrapping result from a clamped one and the upper clamp from the lower. Pairing the most negative value with zero also tells a signed comparison apart from an unsigned one, and the all-ones patterns show whether a carry escaped into a neighbouring lane. Random operands with random flags then run back-to-back to cover ordinary mixed lanes and consecutive valid cycles, and the scalar cases show whether the upper lanes are copied from src_a.

// File: rtl/packed_lane_alu.sv
module packed_lane_alu #(
  parameter int DATA_W     = 64,
  parameter int SAT_BIT    = 1,
  parameter int SIGN_BIT   = 6,
  parameter int SCALAR_BIT = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [1:0]        lane_sz,
  input  logic [1:0]        op,
  input  logic [7:0]        ctrl,
  output logic [DATA_W-1:0] res,
  output logic              out_valid
);

  localparam int NSIZES = 4;

  logic sat, sgn, scalar;
  assign sat    = ctrl[SAT_BIT];
  assign sgn    = ctrl[SIGN_BIT];
  assign scalar = ctrl[SCALAR_BIT];

  function automatic logic [63:0] lane_calc(input logic [63:0] a, input logic [63:0] b,
                                            input int w, input logic [1:0] code,
                                            input logic do_sat, input logic is_sgn);
    logic [64:0] s, d;
    logic [63:0] msk, top, r, ax, bx;
    logic sa, sb, sr, a_lt_b, b_lt_a;
    msk = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    top = 64'd1 << (w - 1);
    s   = {1'b0, a} + {1'b0, b};
    d   = {1'b0, a} - {1'b0, b};
    sa  = |(a & top);
    sb  = |(b & top);
    ax  = sa ? (a | ~msk) : a;
    bx  = sb ? (b | ~msk) : b;
    a_lt_b = is_sgn ? ($signed(ax) < $signed(bx)) : (a < b);
    b_lt_a = is_sgn ? ($signed(bx) < $signed(ax)) : (b < a);
    r = '0;
    case (code)
      2'd0: begin
        r  = s[63:0] & msk;
        sr = |(r & top);
        if (do_sat) begin
          if (is_sgn) begin
            if (sa == sb && sr != sa) r = sr ? (msk >> 1) : top;
          end else if (s[64] || (s[63:0] & ~msk) != 64'd0) begin
            r = msk;
          end
        end
      end
      2'd1: begin
        r  = d[63:0] & msk;
        sr = |(r & top);
        if (do_sat) begin
          if (is_sgn) begin
            if (sa != sb && sr != sa) r = sr ? (msk >> 1) : top;
          end else if (b > a) begin
            r = '0;
          end
        end
      end
      2'd2:    r = a_lt_b ? a : b;
      default: r = b_lt_a ? a : b;
    endcase
    return r;
  endfunction

  logic [DATA_W-1:0] by_size [NSIZES];

  for (genvar sz = 0; sz < NSIZES; sz++) begin : g_sz
    localparam int LW = 8 << sz;
    localparam int NL = DATA_W / LW;
    logic [DATA_W-1:0] packed_r;
    for (genvar k = 0; k < NL; k++) begin : g_lane
      logic [63:0] lane_r;
      assign lane_r = lane_calc(64'(src_a[k*LW +: LW]), 64'(src_b[k*LW +: LW]),
                                LW, op, sat, sgn);
      assign packed_r[k*LW +: LW] = lane_r[LW-1:0];
    end
    assign by_size[sz] = packed_r;
  end

  logic [DATA_W-1:0] low_mask, next_res;

  always_comb begin
    low_mask = (lane_sz == 2'd3) ? '1 : DATA_W'((64'd1 << (8 << lane_sz)) - 64'd1);
    next_res = scalar ? ((by_size[lane_sz] & low_mask) | (src_a & ~low_mask))
                      : by_size[lane_sz];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res       <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) res <= next_res;
    end
  end

  assert_reset_R10: assert property (@(posedge clk)
    rst |=> (!out_valid && res == '0));

  assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(res)));

  assert_scalar_byte_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && scalar && lane_sz == 2'd0) |=> res[DATA_W-1:8] == $past(src_a[DATA_W-1:8]));

  assert_scalar_word_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && scalar && lane_sz == 2'd2) |=> res[DATA_W-1:32] == $past(src_a[DATA_W-1:32]));

  assert_usat_add_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'd0 && sat && !sgn && !scalar && lane_sz == 2'd3)
      |=> (res >= $past(src_a) && res >= $past(src_b)));

  assert_umax_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'd3 && !sgn && !scalar && lane_sz == 2'd3)
      |=> ((res == $past(src_a) || res == $past(src_b))
           && res >= $past(src_a) && res >= $past(src_b)));

endmodule

// File: tb/packed_lane_alu_test.sv
`timescale 1ns/1ps
module packed_lane_alu_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] src_a = '0, src_b = '0;
  logic [1:0]  lane_sz = '0, op = '0;
  logic [7:0]  ctrl = '0;
  logic [63:0] res;
  logic        out_valid;

  int total = 0, fails = 0, cyc = 0;
  logic [63:0] exp_q[$];
  string       tag_q[$];
  int          cyc_q[$];
  logic [63:0] last_exp = '0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  packed_lane_alu uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
    .lane_sz(lane_sz), .op(op), .ctrl(ctrl), .res(res), .out_valid(out_valid)
  );

  function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                        input logic [1:0] sz, input logic [1:0] code,
                                        input logic [7:0] c);
    int w, n;
    logic [63:0] r, msk, la, lb, lo_out;
    logic signed [66:0] p, xa, xb, ex, lo, hi;
    w   = 8 << sz;
    n   = c[7] ? 1 : 64 / w;
    msk = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    p   = 67'sd1 <<< w;
    r   = a;
    for (int k = 0; k < n; k++) begin
      la = (a >> (k * w)) & msk;
      lb = (b >> (k * w)) & msk;
      xa = $signed({3'b0, la});
      xb = $signed({3'b0, lb});
      if (c[6]) begin
        if (la[w-1]) xa = xa - p;
        if (lb[w-1]) xb = xb - p;
      end
      lo_out = '0;
      if (code < 2) begin
        ex = (code == 0) ? xa + xb : xa - xb;
        if (c[1]) begin
          lo = c[6] ? -(p >>> 1) : 67'sd0;
          hi = c[6] ? (p >>> 1) - 1 : p - 1;
          if (ex < lo) ex = lo;
          if (ex > hi) ex = hi;
        end
        lo_out = ex[63:0] & msk;
      end else if (code == 2) begin
        lo_out = (xa < xb) ? la : lb;
      end else begin
        lo_out = (xa > xb) ? la : lb;
      end
      r = (r & ~(msk << (k * w))) | (lo_out << (k * w));
    end
    return r;
  endfunction

  function automatic string req_of(input logic [1:0] code, input logic [7:0] c);
    if (c[7])      return "R8";
    if (code >= 2) return "R7";
    if (!c[1])     return "R1/R2";
    if (!c[6])     return (code == 0) ? "R3" : "R4";
    return (code == 0) ? "R5" : "R6";
  endfunction

  function automatic logic [63:0] pattern(input logic [1:0] sz, input int idx);
    int w;
    logic [63:0] msk, lane, r;
    w   = 8 << sz;
    msk = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    case (idx)
      0:       lane = '0;
      1:       lane = msk;
      2:       lane = 64'd1 << (w - 1);
      3:       lane = msk >> 1;
      default: lane = 64'd1;
    endcase
    r = '0;
    for (int k = 0; k < 64 / w; k++) r = r | (lane << (k * w));
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [63:0] a, input logic [63:0] b, input logic [1:0] sz,
                       input logic [1:0] code, input logic [7:0] c, input bit gap);
    @(negedge clk);
    src_a = a; src_b = b; lane_sz = sz; op = code; ctrl = c; in_valid = 1'b1;
    exp_q.push_back(model(a, b, sz, code, c));
    tag_q.push_back(req_of(code, c));
    cyc_q.push_back(cyc);
    if (gap) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9", {63'd0, out_valid}, 64'd0);
      end else begin
        logic [63:0] e;
        string t;
        int c0;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        c0 = cyc_q.pop_front();
        last_exp = e;
        check(res == e, t, res, e);
        check(cyc == c0 + 1, "R9", 64'(cyc), 64'(c0 + 1));
      end
    end
  end

  initial begin
    logic [7:0] modes [6];
    modes = '{8'h00, 8'h40, 8'h02, 8'h42, 8'hC2, 8'h82};
    repeat (3) @(negedge clk);
    check(res == '0 && out_valid == 1'b0, "R10", res, 64'd0);
    rst = 1'b0;
    for (int sz = 0; sz < 4; sz++)
      for (int o = 0; o < 4; o++)
        for (int m = 0; m < 6; m++)
          for (int pa = 0; pa < 5; pa++)
            for (int pb = 0; pb < 5; pb++)
              drive(pattern(2'(sz), pa), pattern(2'(sz), pb), 2'(sz), 2'(o), modes[m], 1'b1);
    for (int i = 0; i < 400; i++)
      drive({$urandom, $urandom}, {$urandom, $urandom}, 2'($urandom), 2'($urandom),
            modes[$urandom % 6], 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && res == last_exp, "R9", res, last_exp);
    check(exp_q.size() == 0, "R9", 64'(exp_q.size()), 64'd0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog R9 actual=%0d expected=%0d", exp_q.size(), 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule